// File: doc/BRIEF.md
# ADC Conversion Sequencer

This controller sits between an ADC conversion engine and its result buffer. Each pulse on `conv_done` marks one finished conversion. On each pulse the block moves to the next channel of the current sample and advances the result-buffer write address. It also counts conversions against a 5-bit rate value. When the count reaches that rate, the block issues either an interrupt pulse or a DMA address-step pulse, depending on the DMA-mode input.

Configuration arrives as plain input ports:
- the channel-group code
- the scan enable and its 16-bit input mask
- the 12-bit resolution mode
- the split (ping-pong) buffer mode
- the DMA mode
- the rate value

In split mode the 16-entry buffer works as two halves of 8 entries. Every interrupt swaps the half being written and moves the write address to the base of the new half. A half flag reports which half is being filled.

A three-state controller governs the block:
- **OFF**: held while `enable` is low. Everything is cleared.
- **ARM**: a one-cycle restart entered from OFF when `enable` rises, or from RUN when any configuration input changes. It clears the conversion counter, channel index, write address, half flag and scan position. It returns to OFF if `enable` drops, stays in ARM while the configuration keeps changing, and otherwise moves to RUN.
- **RUN**: the only state in which `conv_done` is accepted. It moves to OFF when `enable` drops and to ARM on a configuration change.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With `cfg_dma`=0, `irq_pulse` is high for one cycle, in the cycle after every (cfg_rate[3:0]+1)-th accepted conversion. cfg_rate[4] has no effect in this mode and `dma_step_pulse` stays low.
- R2: With `cfg_dma`=1, `dma_step_pulse` is high for one cycle, in the cycle after every (cfg_rate+1)-th accepted conversion, so the rate runs from 1 to 32. `irq_pulse` stays low in this mode.
- R3: `conv_chan` gives the channel of the next conversion. It steps by one on each accepted conversion and wraps after the last channel of the group. The group is set by `cfg_chan_mode`: code 0 gives channel 0 only, code 1 gives channels 0 and 1, and codes 2 and 3 give channels 0 to 3.
- R4: With `cfg_res12`=1, `cfg_chan_mode` is ignored and `conv_chan` stays 0.
- R5: With `cfg_scan_en`=1, `ch0_src` starts at the lowest set bit of `cfg_scan_mask`, or at 0 if the mask is empty. After each completed sample (the conversion on the last channel of the group), it moves to the next set mask bit above the current one, wrapping round to the lowest. With `cfg_scan_en`=0, `ch0_src` is 0.
- R6: With `cfg_split`=0, `wr_addr` rises by one on each accepted conversion and wraps modulo 16. It returns to 0 on each conversion that raises an interrupt.
- R7: With `cfg_split`=1, `half_flag` is 1 while the upper half (addresses 8 to 15) is being filled and 0 while the lower half is. Each conversion that raises an interrupt toggles `half_flag` and sets `wr_addr` to 8 times the new flag. Otherwise `wr_addr` steps within its half, wrapping after 8 entries. With `cfg_split`=0, `half_flag` reads 0.
- R8: While `enable` is low, and during the restart that follows a change of any configuration input, `conv_done` is ignored. After that restart, the counter, `conv_chan`, `wr_addr`, `half_flag` and the scan position are back at their start values.
- R9: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable |
| conv_done | input | 1 | One-cycle pulse per finished conversion |
| cfg_chan_mode | input | 2 | Channel-group code |
| cfg_scan_en | input | 1 | Step channel 0 through the scan mask |
| cfg_res12 | input | 1 | 12-bit mode, single channel |
| cfg_split | input | 1 | Ping-pong buffer halves |
| cfg_dma | input | 1 | Rate counter drives DMA steps instead of interrupts |
| cfg_rate | input | 5 | Conversions per event, minus one |
| cfg_scan_mask | input | 16 | Inputs taking part in the scan |
| conv_chan | output | 2 | Channel of the next conversion |
| ch0_src | output | 4 | Input selected for channel 0 |
| wr_addr | output | 4 | Buffer address for the next result |
| half_flag | output | 1 | Buffer half being filled |
| irq_pulse | output | 1 | Interrupt pulse |
| dma_step_pulse | output | 1 | DMA address-step pulse |

## Verification
The bench builds the block with its default parameters: a 16-entry buffer, 16 scan inputs and a 5-bit rate. At these sizes it can sweep all 32 rate codes in both DMA and interrupt mode, with 70 conversions per code. That is enough to cover several events at the slowest rate, repeated half swaps, and wraps of the address inside a half and across the full buffer.

Each sweep point changes the channel group, the resolution mode, the scan enable and the scan mask together. This covers empty and single-bit masks as well as wrapping scans. Separate directed cases pulse `conv_done` while the block is disabled and on the same edge as a configuration change.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    parameter int RATE_W = 5;
    parameter int SCAN_N = 16;
    parameter int SCAN_W = $clog2(SCAN_N);
    parameter int CHAN_W = 2;
    parameter int ADDR_W = 4;

    typedef enum logic [1:0] {ST_OFF, ST_ARM, ST_RUN} seq_state_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan_mode;
        logic              scan_en;
        logic              res12;
        logic              split;
        logic              dma;
        logic [RATE_W-1:0] rate;
        logic [SCAN_N-1:0] mask;
    } seq_cfg_t;
endpackage

// File: rtl/adcseq_rate_counter.sv
module adcseq_rate_counter #(
    parameter int RATE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              dma_mode,
    input  logic [RATE_W-1:0] rate,
    output logic              hit,
    output logic              irq_pulse,
    output logic              dma_pulse
);
    logic [RATE_W-1:0] cnt;
    logic [RATE_W-1:0] lim;

    // Interrupt mode uses the low bits only; DMA mode uses the full field.
    assign lim = dma_mode ? rate : {1'b0, rate[RATE_W-2:0]};
    assign hit = step && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            irq_pulse <= 1'b0;
            dma_pulse <= 1'b0;
        end else if (clear) begin
            cnt       <= '0;
            irq_pulse <= 1'b0;
            dma_pulse <= 1'b0;
        end else begin
            irq_pulse <= hit && !dma_mode;
            dma_pulse <= hit && dma_mode;
            if (step) cnt <= hit ? '0 : cnt + 1'b1;
        end
    end

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n || clear)
        cnt <= lim);
endmodule

// File: rtl/adcseq_scan_pick.sv
module adcseq_scan_pick #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic [N-1:0] mask,
    input  logic [W-1:0] cur,
    output logic [W-1:0] first_idx,
    output logic [W-1:0] next_idx
);
    always_comb begin
        logic found;
        found     = 1'b0;
        first_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && mask[i]) begin
                first_idx = W'(i);
                found     = 1'b1;
            end
        end
    end

    always_comb begin
        logic         found;
        logic [W-1:0] cand;
        found    = 1'b0;
        next_idx = cur;
        for (int k = 1; k <= N; k++) begin
            cand = cur + W'(k);
            if (!found && mask[cand]) begin
                next_idx = cand;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/adcseq_buf_addr.sv
module adcseq_buf_addr #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              wrap_evt,
    input  logic              split,
    output logic [ADDR_W-1:0] addr,
    output logic              half
);
    localparam int LOW_W = ADDR_W - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
            half <= 1'b0;
        end else if (clear) begin
            addr <= '0;
            half <= 1'b0;
        end else if (step) begin
            if (wrap_evt) begin
                if (split) begin
                    half <= ~half;
                    addr <= {~half, {LOW_W{1'b0}}};
                end else begin
                    addr <= '0;
                end
            end else if (split) begin
                addr <= {half, addr[LOW_W-1:0] + 1'b1};
            end else begin
                addr <= addr + 1'b1;
            end
        end
    end

    assert_half_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wrap_evt && split && !clear) |=> (addr[LOW_W-1:0] == '0 && addr[ADDR_W-1] == half));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adcseq_pkg::*;
#(
    parameter int P_RATE_W = RATE_W,
    parameter int P_SCAN_N = SCAN_N,
    parameter int P_ADDR_W = ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic                       conv_done,
    input  logic [CHAN_W-1:0]          cfg_chan_mode,
    input  logic                       cfg_scan_en,
    input  logic                       cfg_res12,
    input  logic                       cfg_split,
    input  logic                       cfg_dma,
    input  logic [RATE_W-1:0]          cfg_rate,
    input  logic [SCAN_N-1:0]          cfg_scan_mask,
    output logic [CHAN_W-1:0]          conv_chan,
    output logic [SCAN_W-1:0]          ch0_src,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic                       half_flag,
    output logic                       irq_pulse,
    output logic                       dma_step_pulse
);
    localparam int SW = $clog2(P_SCAN_N);

    seq_state_e  state, nxt_state;
    seq_cfg_t    cfg_in, cfg_q;
    logic        cfg_changed, clear, accept, hit;
    logic [CHAN_W-1:0] ch_idx, ch_last;
    logic [SW-1:0]     scan_idx, scan_first, scan_next;
    logic        half;

    assign cfg_in = '{chan_mode: cfg_chan_mode, scan_en: cfg_scan_en, res12: cfg_res12,
                      split: cfg_split, dma: cfg_dma, rate: cfg_rate, mask: cfg_scan_mask};
    assign cfg_changed = (cfg_in != cfg_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cfg_q <= '0;
        end else begin
            state <= nxt_state;
            cfg_q <= cfg_in;
        end
    end

    always_comb begin
        nxt_state = state;
        clear     = 1'b0;
        accept    = 1'b0;
        unique case (state)
            ST_OFF: begin
                clear = 1'b1;
                if (enable) nxt_state = ST_ARM;
            end
            ST_ARM: begin
                clear = 1'b1;
                if (!enable)          nxt_state = ST_OFF;
                else if (!cfg_changed) nxt_state = ST_RUN;
            end
            ST_RUN: begin
                if (!enable)          nxt_state = ST_OFF;
                else if (cfg_changed) nxt_state = ST_ARM;
                else                  accept = conv_done;
            end
            default: nxt_state = ST_OFF;
        endcase
    end

    // Last channel of the group; 12-bit mode forces a single channel.
    always_comb begin
        if (cfg_q.res12)             ch_last = '0;
        else if (cfg_q.chan_mode[1]) ch_last = CHAN_W'(3);
        else if (cfg_q.chan_mode[0]) ch_last = CHAN_W'(1);
        else                         ch_last = '0;
    end

    adcseq_scan_pick #(.N(P_SCAN_N), .W(SW)) scan_i (
        .mask      (cfg_q.mask),
        .cur       (scan_idx),
        .first_idx (scan_first),
        .next_idx  (scan_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_idx   <= '0;
            scan_idx <= '0;
        end else if (clear) begin
            ch_idx   <= '0;
            scan_idx <= scan_first;
        end else if (accept) begin
            if (ch_idx == ch_last) begin
                ch_idx <= '0;
                if (cfg_q.scan_en) scan_idx <= scan_next;
            end else begin
                ch_idx <= ch_idx + 1'b1;
            end
        end
    end

    adcseq_rate_counter #(.RATE_W(P_RATE_W)) rate_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .step      (accept),
        .dma_mode  (cfg_q.dma),
        .rate      (cfg_q.rate),
        .hit       (hit),
        .irq_pulse (irq_pulse),
        .dma_pulse (dma_step_pulse)
    );

    adcseq_buf_addr #(.ADDR_W(P_ADDR_W)) addr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .step     (accept),
        .wrap_evt (hit && !cfg_q.dma),
        .split    (cfg_q.split),
        .addr     (wr_addr),
        .half     (half)
    );

    assign conv_chan = ch_idx;
    assign ch0_src   = cfg_q.scan_en ? scan_idx : '0;
    assign half_flag = half;

    assert_pulse_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_pulse && dma_step_pulse));
    assert_irq_after_conv_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(accept));
    assert_single_chan_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && cfg_q.res12) |-> (conv_chan == '0));
    assert_flag_low_unsplit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !cfg_q.split) |-> !half_flag);
    assert_scan_in_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && (|cfg_q.mask)) |-> cfg_q.mask[scan_idx]);
    assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM) |=> (conv_chan == '0 && wr_addr == '0 && !half_flag));
endmodule

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        conv_done = 1'b0;
    logic [1:0]  cfg_chan_mode = '0;
    logic        cfg_scan_en = 1'b0;
    logic        cfg_res12 = 1'b0;
    logic        cfg_split = 1'b0;
    logic        cfg_dma = 1'b0;
    logic [4:0]  cfg_rate = '0;
    logic [15:0] cfg_scan_mask = '0;
    logic [1:0]  conv_chan;
    logic [3:0]  ch0_src;
    logic [3:0]  wr_addr;
    logic        half_flag, irq_pulse, dma_step_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // model state
    int m_cnt, m_ch, m_addr, m_half, m_scan;

    always #2.5 clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .conv_done(conv_done),
        .cfg_chan_mode(cfg_chan_mode), .cfg_scan_en(cfg_scan_en), .cfg_res12(cfg_res12),
        .cfg_split(cfg_split), .cfg_dma(cfg_dma), .cfg_rate(cfg_rate),
        .cfg_scan_mask(cfg_scan_mask), .conv_chan(conv_chan), .ch0_src(ch0_src),
        .wr_addr(wr_addr), .half_flag(half_flag), .irq_pulse(irq_pulse),
        .dma_step_pulse(dma_step_pulse)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int lowest_set(input logic [15:0] m);
        for (int i = 0; i < 16; i++) if (m[i]) return i;
        return 0;
    endfunction

    function automatic int next_set(input logic [15:0] m, input int cur);
        for (int k = 1; k <= 16; k++) if (m[(cur + k) % 16]) return (cur + k) % 16;
        return cur;
    endfunction

    task automatic model_restart();
        m_cnt = 0; m_ch = 0; m_addr = 0; m_half = 0;
        m_scan = lowest_set(cfg_scan_mask);
    endtask

    task automatic pulse_conv();
        @(negedge clk); conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
    endtask

    // One accepted conversion, model update and full output comparison.
    task automatic conv_and_check();
        int lim, n;
        bit hit, last;
        pulse_conv();
        lim  = cfg_dma ? int'(cfg_rate) : int'(cfg_rate[3:0]);
        hit  = (m_cnt == lim);
        m_cnt = hit ? 0 : m_cnt + 1;
        n = cfg_res12 ? 1 : (cfg_chan_mode[1] ? 4 : (cfg_chan_mode[0] ? 2 : 1));
        last = (m_ch == n - 1);
        m_ch = last ? 0 : m_ch + 1;
        if (last && cfg_scan_en) m_scan = next_set(cfg_scan_mask, m_scan);
        if (hit && !cfg_dma) begin
            if (cfg_split) begin m_half = 1 - m_half; m_addr = m_half * 8; end
            else m_addr = 0;
        end else if (cfg_split) m_addr = m_half * 8 + ((m_addr + 1) % 8);
        else m_addr = (m_addr + 1) % 16;
        chk(irq_pulse, (hit && !cfg_dma) ? 1 : 0, "R1 irq_pulse");
        chk(dma_step_pulse, (hit && cfg_dma) ? 1 : 0, "R2 dma_step_pulse");
        chk(conv_chan, m_ch, cfg_res12 ? "R4 conv_chan" : "R3 conv_chan");
        chk(ch0_src, cfg_scan_en ? m_scan : 0, "R5 ch0_src");
        chk(wr_addr, m_addr, cfg_split ? "R7 wr_addr" : "R6 wr_addr");
        chk(half_flag, m_half, "R7 half_flag");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values
        chk(conv_chan, 0, "R9 conv_chan");
        chk(ch0_src, 0, "R9 ch0_src");
        chk(wr_addr, 0, "R9 wr_addr");
        chk(half_flag, 0, "R9 half_flag");
        chk(irq_pulse, 0, "R9 irq_pulse");
        chk(dma_step_pulse, 0, "R9 dma_step_pulse");
        rst_n = 1'b1;
        @(negedge clk);

        // R8: conversions while disabled are ignored
        pulse_conv();
        pulse_conv();
        chk(wr_addr, 0, "R8 disabled wr_addr");
        chk(conv_chan, 0, "R8 disabled conv_chan");
        chk(irq_pulse, 0, "R8 disabled irq_pulse");

        enable = 1'b1;
        for (int d = 0; d < 2; d++) begin
            for (int r = 0; r < 32; r++) begin
                logic [4:0] rv;
                rv = 5'(r);
                @(negedge clk);
                cfg_dma       = d[0];
                cfg_rate      = rv;
                cfg_chan_mode = rv[1:0];
                cfg_res12     = (r % 5 == 3);
                cfg_split     = rv[0] ^ d[0] ^ rv[2];
                cfg_scan_en   = (r % 3 != 0);
                cfg_scan_mask = (r == 7) ? 16'h0 :
                                ((16'h1 << rv[3:0]) | (16'h0100 >> rv[2:0]) | (rv[4] ? 16'h8000 : 16'h0));
                repeat (3) @(negedge clk);
                model_restart();
                // R8: outputs back at start values after restart
                chk(wr_addr, 0, "R8 restart wr_addr");
                chk(conv_chan, 0, "R8 restart conv_chan");
                chk(ch0_src, cfg_scan_en ? m_scan : 0, "R5 start ch0_src");
                for (int c = 0; c < 70; c++) conv_and_check();
            end
        end

        // R8: conversion on the same edge as a configuration change is dropped
        @(negedge clk);
        cfg_dma = 1'b0; cfg_split = 1'b1; cfg_rate = 5'd3; cfg_res12 = 1'b0; cfg_chan_mode = 2'd2;
        repeat (3) @(negedge clk);
        model_restart();
        for (int c = 0; c < 5; c++) conv_and_check();
        @(negedge clk);
        cfg_rate = 5'd2; conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        repeat (2) @(negedge clk);
        chk(wr_addr, 0, "R8 change wr_addr");
        chk(half_flag, 0, "R8 change half_flag");
        chk(conv_chan, 0, "R8 change conv_chan");
        model_restart();
        for (int c = 0; c < 8; c++) conv_and_check();

        // R8: disable mid-run clears state
        @(negedge clk); enable = 1'b0;
        pulse_conv();
        @(negedge clk);
        chk(wr_addr, 0, "R8 disable wr_addr");
        chk(conv_chan, 0, "R8 disable conv_chan");
        enable = 1'b1;
        repeat (3) @(negedge clk);
        model_restart();
        for (int c = 0; c < 6; c++) conv_and_check();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule